// File: doc/BRIEF.md
# Link Power Handshake and Link-On Controller

This block runs in the physical-layer clock domain and tracks whether the attached link-layer controller is powered. It samples the link power status input and filters it in two separate ways. A long unbroken run of low samples is needed before the link counts as powered down. A very short run of high samples is enough for it to count as powered up. The qualified result drives the enable of the PHY-to-link data interface. Repeater operation on the bus is outside this block and continues whatever the enable does.

A single package pin has two jobs. While hardware reset is held low, the pin is an input. Its level is captured as the default bus-manager contender bit, where high means contender, and a registered copy is kept for self-identification. Once reset is released, the block drives the pin as the link-on output. When a link-on indication arrives from the bus while the link is down, the pin carries a square wave with an 8-cycle period, 4 cycles high and 4 cycles low. The wave ends, and the pin is held low, as soon as the link qualifies as powered up.

A three-state machine controls the behaviour:
- ST_DOWN: the link is down and the pin is quiet.
- ST_WAKE: the link-on wave is running.
- ST_UP: the link is up and the interface is enabled.

Its transitions are:
- DOWN_TO_WAKE: a link-on indication arrives.
- DOWN_TO_UP and WAKE_TO_UP: the link qualifies as powered up.
- UP_TO_DOWN: the link qualifies as powered down.

DOWN_TO_UP takes priority over DOWN_TO_WAKE.

Top module: `linkpwr_ctrl`

## Requirements
- R1: While `rst_n` is low, `contender` follows `lkon_pin_in` at each rising edge. After release it holds the last value captured in reset, whatever the pin does.
- R2: `lkon_oe` is 0 after any edge with `rst_n` low, and 1 from the first edge with `rst_n` high. `lkon_out` is never 1 while `lkon_oe` is 0.
- R3: The link qualifies as up at the edge where `lps_in` has been sampled high on UP_CYC consecutive edges (default 1). `llc_if_en` becomes 1 one edge later.
- R4: The link qualifies as down at the edge where `lps_in` has been sampled low on DOWN_CYC consecutive edges (default 1229, about 25 µs). `llc_if_en` becomes 0 one edge later.
- R5: Any change of the sampled `lps_in` level restarts both run counts. A low run shorter than DOWN_CYC therefore leaves `llc_if_en` at 1.
- R6: In ST_DOWN, `lkon_pkt_in` sampled high moves the machine to ST_WAKE. `lkon_out` is then 1 for 4 cycles and 0 for 4 cycles, repeating, and the first high cycle follows that edge directly.
- R7: Up-qualification in ST_WAKE moves the machine to ST_UP. `lkon_out` goes to 0 and `llc_if_en` goes to 1 in the same cycle.
- R8: `lkon_pkt_in` has no effect in ST_UP, where `lkon_out` stays 0. In ST_WAKE it does not restart the wave phase.
- R9: After reset the machine is in ST_DOWN, with `llc_if_en` = 0 and `lkon_out` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Hardware reset, active low, synchronous |
| lps_in | input | 1 | Link power status from the link controller |
| lkon_pin_in | input | 1 | Pin level, read as the contender strap during reset |
| lkon_pkt_in | input | 1 | One-cycle pulse: link-on indication received from the bus |
| lkon_out | output | 1 | Link-on square wave driven onto the shared pin |
| lkon_oe | output | 1 | Output enable for the shared pin |
| contender | output | 1 | Captured contender bit, 1 means contender |
| llc_if_en | output | 1 | Enable of the PHY-to-link data interface |

## Verification
Each result has a fixed latency:
- With UP_CYC=1, `llc_if_en` rises two edges after the first high sample of `lps_in`.
- `llc_if_en` falls DOWN_CYC+1 edges after the first low sample.
- `lkon_out` is already high in the cycle after the edge that samples `lkon_pkt_in`.
- `lkon_oe` rises after the first edge out of reset.

The bench drives inputs on the falling edge and steps its own port-level model at the rising edge. It compares all outputs at the next falling edge, so each expected value lines up with the cycle in which these register delays say it is due. Directed runs of exactly DOWN_CYC-1 and DOWN_CYC low samples target the boundary of R4 and R5.

// File: rtl/lpc_pkg.sv
package lpc_pkg;
    typedef enum logic [1:0] {
        ST_DOWN = 2'd0,
        ST_WAKE = 2'd1,
        ST_UP   = 2'd2
    } lpc_state_e;
endpackage

// File: rtl/lpc_lps_qual.sv
// Asymmetric run-length filter for the link power status input.
module lpc_lps_qual #(
    parameter int DOWN_CYC = 1229,
    parameter int UP_CYC   = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lps_in,
    output logic link_up
);
    localparam int SAT   = (DOWN_CYC > UP_CYC) ? DOWN_CYC : UP_CYC;
    localparam int CNT_W = $clog2(SAT + 1);
    localparam logic [CNT_W-1:0] SAT_V = CNT_W'(SAT);
    localparam logic [CNT_W-1:0] UP_TH = CNT_W'(UP_CYC);
    localparam logic [CNT_W-1:0] DN_TH = CNT_W'(DOWN_CYC);
    localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);

    logic             lvl_q;
    logic [CNT_W-1:0] run_q;
    logic [CNT_W-1:0] run_nx;
    logic             up_q;

    // run length of the current level, restarting at one on any change
    always_comb begin
        if (lps_in != lvl_q) begin
            run_nx = ONE;
        end else if (run_q == SAT_V) begin
            run_nx = run_q;
        end else begin
            run_nx = run_q + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lvl_q <= 1'b0;
            run_q <= '0;
            up_q  <= 1'b0;
        end else begin
            lvl_q <= lps_in;
            run_q <= run_nx;
            if (lps_in && (run_nx >= UP_TH)) begin
                up_q <= 1'b1;
            end else if (!lps_in && (run_nx >= DN_TH)) begin
                up_q <= 1'b0;
            end
        end
    end

    assign link_up = up_q;
endmodule

// File: rtl/lpc_lkon_wave.sv
// Square wave generator: HALF cycles high, then HALF cycles low.
module lpc_lkon_wave #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic wave
);
    localparam int PH_W = $clog2(2 * HALF);
    localparam logic [PH_W-1:0] LAST = PH_W'(2 * HALF - 1);
    localparam logic [PH_W-1:0] HI_N = PH_W'(HALF);

    logic [PH_W-1:0] phase_q;

    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            phase_q <= '0;
        end else if (phase_q == LAST) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + PH_W'(1);
        end
    end

    assign wave = run && (phase_q < HI_N);
endmodule

// File: rtl/lpc_strap.sv
// Captures the contender strap during reset and enables the pin driver afterwards.
module lpc_strap (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_in,
    output logic contender,
    output logic pin_oe
);
    logic cont_q;
    logic oe_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cont_q <= pin_in;
            oe_q   <= 1'b0;
        end else begin
            oe_q   <= 1'b1;
        end
    end

    assign contender = cont_q;
    assign pin_oe    = oe_q;
endmodule

// File: rtl/linkpwr_ctrl.sv
module linkpwr_ctrl
    import lpc_pkg::*;
#(
    parameter int DOWN_CYC  = 1229,
    parameter int UP_CYC    = 1,
    parameter int LKON_HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lps_in,
    input  logic lkon_pin_in,
    input  logic lkon_pkt_in,
    output logic lkon_out,
    output logic lkon_oe,
    output logic contender,
    output logic llc_if_en
);
    lpc_state_e state_q;
    lpc_state_e state_nx;
    logic       link_up;
    logic       wave_run;
    logic       wave;

    lpc_lps_qual #(
        .DOWN_CYC (DOWN_CYC),
        .UP_CYC   (UP_CYC)
    ) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .lps_in  (lps_in),
        .link_up (link_up)
    );

    lpc_lkon_wave #(
        .HALF (LKON_HALF)
    ) u_wave (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (wave_run),
        .wave  (wave)
    );

    lpc_strap u_strap (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (lkon_pin_in),
        .contender (contender),
        .pin_oe    (lkon_oe)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_DOWN;
        end else begin
            state_q <= state_nx;
        end
    end

    // transitions
    always_comb begin
        state_nx = state_q;
        unique case (state_q)
            ST_DOWN: begin
                if (link_up) begin
                    state_nx = ST_UP;
                end else if (lkon_pkt_in) begin
                    state_nx = ST_WAKE;
                end
            end
            ST_WAKE: begin
                if (link_up) begin
                    state_nx = ST_UP;
                end
            end
            ST_UP: begin
                if (!link_up) begin
                    state_nx = ST_DOWN;
                end
            end
            default: state_nx = ST_DOWN;
        endcase
    end

    // outputs
    always_comb begin
        llc_if_en = (state_q == ST_UP);
        wave_run  = (state_q == ST_WAKE);
        lkon_out  = wave && lkon_oe;
    end
endmodule

// File: rtl/lpc_checker.sv
module lpc_checker (
    input logic clk,
    input logic rst_n,
    input logic lps_in,
    input logic lkon_out,
    input logic lkon_oe,
    input logic contender,
    input logic llc_if_en
);
    AST_CONT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(contender)); // R1

    AST_OE_AFTER_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> lkon_oe); // R2

    AST_OUT_NEEDS_OE: assert property (@(posedge clk) disable iff (!rst_n)
        !lkon_oe |-> !lkon_out); // R2

    AST_UP_NEEDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(llc_if_en) |-> $past(lps_in, 2)); // R3

    AST_DOWN_NEEDS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(llc_if_en) |-> !$past(lps_in, 2)); // R4

    AST_NO_WAVE_WHEN_UP: assert property (@(posedge clk) disable iff (!rst_n)
        llc_if_en |-> !lkon_out); // R7
endmodule

bind linkpwr_ctrl lpc_checker u_lpc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .lps_in    (lps_in),
    .lkon_out  (lkon_out),
    .lkon_oe   (lkon_oe),
    .contender (contender),
    .llc_if_en (llc_if_en)
);

// File: tb/linkpwr_ctrl_bench.sv
`timescale 1ns/1ps
module linkpwr_ctrl_bench;
    localparam int DN   = 1229;
    localparam int UP   = 1;
    localparam int HALF = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic lps_in = 1'b0;
    logic lkon_pin_in = 1'b0;
    logic lkon_pkt_in = 1'b0;
    logic lkon_out, lkon_oe, contender, llc_if_en;

    int n_chk = 0;
    int n_err = 0;

    // port-level model: 0 down, 1 wake, 2 up
    int m_state, m_phase, m_hi, m_lo;
    bit m_up, m_cont;

    always #2 clk = ~clk;

    linkpwr_ctrl #(.DOWN_CYC(DN), .UP_CYC(UP), .LKON_HALF(HALF)) u_linkpwr_ctrl (
        .clk(clk), .rst_n(rst_n), .lps_in(lps_in), .lkon_pin_in(lkon_pin_in),
        .lkon_pkt_in(lkon_pkt_in), .lkon_out(lkon_out), .lkon_oe(lkon_oe),
        .contender(contender), .llc_if_en(llc_if_en)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", tag, $time, act, exp);
        end
    endtask

    function automatic bit exp_en();
        return m_state == 2;
    endfunction

    function automatic bit exp_out();
        return (m_state == 1) && (m_phase < HALF);
    endfunction

    task automatic model_reset();
        m_state = 0; m_phase = 0; m_hi = 0; m_lo = 0; m_up = 1'b0;
    endtask

    task automatic model_step(input bit l, input bit p);
        int nst;
        nst = m_state;
        case (m_state)
            0: if (m_up) nst = 2; else if (p) nst = 1;
            1: if (m_up) nst = 2;
            default: if (!m_up) nst = 0;
        endcase
        m_phase = (m_state == 1) ? (m_phase + 1) % (2 * HALF) : 0;
        m_state = nst;
        if (l) begin m_hi = m_hi + 1; m_lo = 0; end
        else   begin m_lo = m_lo + 1; m_hi = 0; end
        if (m_hi > DN) m_hi = DN;
        if (m_lo > DN) m_lo = DN;
        if (l && m_hi >= UP) m_up = 1'b1;
        else if (!l && m_lo >= DN) m_up = 1'b0;
    endtask

    // one cycle: drive at falling edge, model at rising edge, compare at next falling edge
    task automatic cyc(input bit l, input bit p);
        lps_in = l;
        lkon_pkt_in = p;
        lkon_pin_in = $urandom % 2;
        @(posedge clk);
        model_step(l, p);
        @(negedge clk);
        chk(llc_if_en == exp_en(), "R3 R4 R5 R7 enable", llc_if_en, exp_en());
        chk(lkon_out == exp_out(), "R6 R7 R8 link-on", lkon_out, exp_out());
        chk(lkon_oe == 1'b1, "R2 oe after reset", lkon_oe, 1);
        chk(contender == m_cont, "R1 contender hold", contender, m_cont);
    endtask

    task automatic hold(input bit l, input int n);
        for (int i = 0; i < n; i++) cyc(l, 1'b0);
    endtask

    task automatic do_reset(input bit strap);
        rst_n = 1'b0;
        lkon_pkt_in = 1'b1;
        lps_in = 1'b1;
        for (int i = 0; i < 3; i++) begin
            lkon_pin_in = (i == 2) ? strap : ~strap;
            @(posedge clk);
            @(negedge clk);
            chk(lkon_oe == 1'b0, "R2 oe in reset", lkon_oe, 0);
            chk(lkon_out == 1'b0, "R2 out in reset", lkon_out, 0);
            chk(contender == lkon_pin_in, "R1 capture", contender, lkon_pin_in);
        end
        m_cont = strap;
        model_reset();
        rst_n = 1'b1;
        hold(1'b0, 3);
        chk(llc_if_en == 1'b0, "R9 enable after reset", llc_if_en, 0);
        chk(lkon_out == 1'b0, "R9 out after reset", lkon_out, 0);
    endtask

    initial begin
        #(4.0 * 200000);
        n_err++;
        $display("FAIL watchdog expired: actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int seed;
        seed = $urandom(32'h5EED_1394);
        @(negedge clk);
        do_reset(1'b1);

        // R6: link-on wave pattern 1111_0000 repeating
        cyc(1'b0, 1'b1);
        chk(lkon_out == 1'b1, "R6 first high", lkon_out, 1);
        for (int i = 1; i < 20; i++) begin
            cyc(1'b0, (i == 6));   // R8: indication mid-wave must not restart phase
            chk(lkon_out == (((i % 8) < 4) ? 1'b1 : 1'b0), "R6 R8 wave phase", lkon_out, ((i % 8) < 4));
        end
        // R7: one high sample ends the wave; enable one edge later
        cyc(1'b1, 1'b0);
        cyc(1'b1, 1'b0);
        chk(llc_if_en == 1'b1 && lkon_out == 1'b0, "R7 up ends wave", llc_if_en, 1);
        // R8: indication while up ignored
        cyc(1'b1, 1'b1);
        hold(1'b1, 10);
        chk(lkon_out == 1'b0, "R8 ignored while up", lkon_out, 0);
        // R5: low run of DN-1 keeps enable
        hold(1'b0, DN - 1);
        cyc(1'b1, 1'b0);
        chk(llc_if_en == 1'b1, "R5 short low run", llc_if_en, 1);
        // R4: exactly DN low samples, enable drops one edge later
        hold(1'b0, DN);
        chk(llc_if_en == 1'b1, "R4 drop not early", llc_if_en, 1);
        cyc(1'b0, 1'b0);
        chk(llc_if_en == 1'b0, "R4 down qualified", llc_if_en, 0);
        // R3: a single high sample qualifies up
        cyc(1'b1, 1'b0);
        cyc(1'b0, 1'b0);
        chk(llc_if_en == 1'b1, "R3 fast up", llc_if_en, 1);

        // random mix
        for (int k = 0; k < 60; k++) begin
            int len, sel;
            bit l;
            l = $urandom % 2;
            sel = $urandom % 6;
            case (sel)
                0: len = 1;
                1: len = 2 + $urandom % 5;
                2: len = DN - 1;
                3: len = DN + ($urandom % 3);
                default: len = 1 + $urandom % 60;
            endcase
            for (int i = 0; i < len; i++) cyc(l, ($urandom % 16) == 0);
        end

        // second reset with strap low
        do_reset(1'b0);
        for (int i = 0; i < 200; i++) cyc(($urandom % 8) != 0, ($urandom % 10) == 0);

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule